// File: doc/BRIEF.md
# Dual-Priority Descriptor Queue Arbiter

This block sits in front of a data-mover engine and collects 160-bit transfer descriptors from two independent streaming sinks: a normal sink and a priority sink. Each sink is a valid/ready stream with a fixed ready latency of three cycles. A sender may drive valid in a cycle only if ready was high three cycles earlier, and the sink captures the word on every cycle where valid is high. Each sink feeds its own FIFO. Because words can already be in flight when ready drops, each FIFO keeps enough space in reserve to absorb them.

The arbiter takes one descriptor at a time from the FIFOs and offers it downstream with a valid/ready handshake. It then waits for a one-cycle done pulse before it picks the next one. The priority FIFO always wins a selection. A normal descriptor that has already been picked still runs to completion. While a descriptor is active, its 8-bit ID (bits [159:152]) is shown on a dedicated output. A per-queue presence bitmap of IDs flags any descriptor whose ID is already waiting in the other queue.

Top module: `desc_prio_arbiter`

## Requirements
- R1: With `LAT` = 3, each sink's ready is low whenever its FIFO has `LAT` or fewer free entries. Every word a sender is allowed to send under the three-cycle rule is stored and none is lost.
- R2: After reset is released, both FIFOs are empty and both ready outputs are low until the first rising clock edge. They are high from that edge on. `issue_valid_o`, `active_o` and `id_collision_o` are low after reset.
- R3: A word is written into a FIFO on every cycle where that sink's valid is high. A correctly paced sender never pushes into a full FIFO.
- R4: Within one queue, descriptors are issued in the order they were accepted.
- R5: Whenever the arbiter makes a selection and the priority FIFO is not empty, the head of the priority FIFO is chosen. A normal descriptor is chosen only when the priority FIFO is empty.
- R6: Only one descriptor is outstanding at a time. Once it has been offered, no other descriptor is taken until `done_i` has been seen, and a priority arrival does not displace it.
- R7: After a run of priority descriptors, the arbiter returns to normal descriptors only once the priority FIFO has drained.
- R8: While `issue_valid_o` is high and `issue_ready_i` is low, `issue_valid_o` stays high and `issue_data_o` stays unchanged.
- R9: `done_i` has no effect unless the arbiter is waiting for completion of an accepted descriptor. A done pulse while a descriptor is still being offered leaves the offer and its data unchanged.
- R10: `id_collision_o` pulses high one cycle after a descriptor is accepted whose ID (bits [159:152]) is present in the other queue, or is pushed into the other queue in the same cycle. An ID stops counting as present once its descriptor has been taken out of its FIFO.
- R11: `active_o` is high from the cycle a descriptor is offered until the cycle after `done_i`. `active_id_o` carries bits [159:152] of that descriptor. `issue_prio_o` is 1 for a descriptor from the priority sink and 0 for one from the normal sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| norm_valid_i | input | 1 | Normal sink word valid |
| norm_data_i | input | 160 | Normal sink descriptor |
| norm_ready_o | output | 1 | Normal sink ready (latency 3) |
| prio_valid_i | input | 1 | Priority sink word valid |
| prio_data_i | input | 160 | Priority sink descriptor |
| prio_ready_o | output | 1 | Priority sink ready (latency 3) |
| issue_valid_o | output | 1 | Descriptor offered to engine |
| issue_ready_i | input | 1 | Engine accepts the offer |
| issue_data_o | output | 160 | Offered descriptor |
| issue_prio_o | output | 1 | Offered descriptor came from the priority sink |
| done_i | input | 1 | Engine completion pulse |
| active_o | output | 1 | A descriptor is offered or in progress |
| active_id_o | output | 8 | ID of the active descriptor |
| id_collision_o | output | 1 | Pulse: accepted ID already held in the other queue |

## Verification
The bench builds the block with the smallest legal FIFO depth of 4 and a ready latency of 3. With these values ready is high only while a FIFO is completely empty. A single burst therefore fills the FIFO to its last entry using only the words already in flight, so the reserve margin in R1 is exercised at its exact edge. The small depth also lets a few pushes held behind a busy engine set up mixed priority/normal backlogs, ID collisions and blocked senders quickly.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
  localparam int unsigned DESC_W  = 160;
  localparam int unsigned ID_W    = 8;
  localparam int unsigned ID_LSB  = 152;
  localparam int unsigned NUM_IDS = 1 << ID_W;

  typedef logic [DESC_W-1:0] desc_t;
  typedef logic [ID_W-1:0]   desc_id_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } arb_state_e;

  function automatic desc_id_t id_of(desc_t d);
    return d[ID_LSB +: ID_W];
  endfunction
endpackage

// File: rtl/dpq_fifo.sv
module dpq_fifo
  import dpq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LAT   = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  desc_t data_i,
  output logic  ready_o,
  input  logic  pop_i,
  output desc_t head_o,
  output logic  nonempty_o
);
  localparam int unsigned PW       = $clog2(DEPTH);
  localparam int unsigned CW       = $clog2(DEPTH + 1);
  localparam int unsigned OPEN_LIM = DEPTH - LAT;

  desc_t          mem_q [DEPTH];
  logic [PW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q;
  logic           init_q;
  logic           do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != CW'(DEPTH)) || do_pop);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      init_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // hold back space for words already launched under the ready latency
  assign ready_o    = init_q && (cnt_q < CW'(OPEN_LIM));
  assign head_o     = mem_q[rd_q];
  assign nonempty_o = (cnt_q != '0);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ((cnt_q != CW'(DEPTH)) || pop_i));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/dpq_id_guard.sv
module dpq_id_guard
  import dpq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          push_i,
  input  logic [1:0][ID_W-1:0] push_id_i,
  input  logic [1:0]          pop_i,
  input  logic [1:0][ID_W-1:0] pop_id_i,
  output logic                id_collision_o
);
  logic [1:0][NUM_IDS-1:0] map_q, map_d;
  logic                    hit;

  always_comb begin
    map_d = map_q;
    for (int q = 0; q < 2; q++) begin
      if (pop_i[q])  map_d[q][pop_id_i[q]]  = 1'b0;
      if (push_i[q]) map_d[q][push_id_i[q]] = 1'b1;
    end
  end

  always_comb begin
    hit = (push_i[0] && map_q[1][push_id_i[0]]) ||
          (push_i[1] && map_q[0][push_id_i[1]]) ||
          (&push_i && (push_id_i[0] == push_id_i[1]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q          <= '0;
      id_collision_o <= 1'b0;
    end else begin
      map_q          <= map_d;
      id_collision_o <= hit;
    end
  end

  p_collision_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_collision_o |-> $past(|push_i));

  p_norm_map_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i[0] |=> map_q[0][$past(push_id_i[0])]);

  p_prio_map_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i[1] |=> map_q[1][$past(push_id_i[1])]);
endmodule

// File: rtl/dpq_issue_ctrl.sv
module dpq_issue_ctrl
  import dpq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      nonempty_i,
  input  desc_t [1:0]     head_i,
  output logic  [1:0]     pop_o,
  output logic            issue_valid_o,
  input  logic            issue_ready_i,
  output desc_t           issue_data_o,
  output logic            issue_prio_o,
  input  logic            done_i,
  output logic            active_o,
  output desc_id_t        active_id_o
);
  arb_state_e state_q;
  desc_t      hold_q;
  logic       prio_q;

  // index 1 = priority queue, strictly ahead of index 0
  always_comb begin
    pop_o = '0;
    if (state_q == ST_IDLE) begin
      if (nonempty_i[1])      pop_o[1] = 1'b1;
      else if (nonempty_i[0]) pop_o[0] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      prio_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (|pop_o) begin
          hold_q  <= pop_o[1] ? head_i[1] : head_i[0];
          prio_q  <= pop_o[1];
          state_q <= ST_OFFER;
        end
        ST_OFFER: if (issue_ready_i) state_q <= ST_WAIT;
        ST_WAIT:  if (done_i)        state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_valid_o = (state_q == ST_OFFER);
  assign issue_data_o  = hold_q;
  assign issue_prio_o  = prio_q;
  assign active_o      = (state_q != ST_IDLE);
  assign active_id_o   = id_of(hold_q);

  p_prio_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o[0] |-> !nonempty_i[1]);

  p_hold_offer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_ready_i) |=> (issue_valid_o && $stable(issue_data_o)));

  p_no_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !done_i) |=> (state_q == ST_WAIT && $stable(hold_q)));

  p_single_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o));

  p_done_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFFER && done_i && !issue_ready_i) |=> (state_q == ST_OFFER));
endmodule

// File: rtl/desc_prio_arbiter.sv
module desc_prio_arbiter
  import dpq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LAT   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          norm_valid_i,
  input  logic [159:0]  norm_data_i,
  output logic          norm_ready_o,
  input  logic          prio_valid_i,
  input  logic [159:0]  prio_data_i,
  output logic          prio_ready_o,
  output logic          issue_valid_o,
  input  logic          issue_ready_i,
  output logic [159:0]  issue_data_o,
  output logic          issue_prio_o,
  input  logic          done_i,
  output logic          active_o,
  output logic [7:0]    active_id_o,
  output logic          id_collision_o
);
  logic [1:0]            push, ready, pop, nonempty;
  desc_t [1:0]           wdata, head;
  logic [1:0][ID_W-1:0]  push_id, pop_id;

  assign push     = {prio_valid_i, norm_valid_i};
  assign wdata[0] = norm_data_i;
  assign wdata[1] = prio_data_i;

  for (genvar q = 0; q < 2; q++) begin : g_queue
    dpq_fifo #(.DEPTH(DEPTH), .LAT(LAT)) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push[q]),
      .data_i     (wdata[q]),
      .ready_o    (ready[q]),
      .pop_i      (pop[q]),
      .head_o     (head[q]),
      .nonempty_o (nonempty[q])
    );
    assign push_id[q] = id_of(wdata[q]);
    assign pop_id[q]  = id_of(head[q]);
  end

  assign norm_ready_o = ready[0];
  assign prio_ready_o = ready[1];

  dpq_id_guard u_guard (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .push_i         (push),
    .push_id_i      (push_id),
    .pop_i          (pop),
    .pop_id_i       (pop_id),
    .id_collision_o (id_collision_o)
  );

  dpq_issue_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .nonempty_i    (nonempty),
    .head_i        (head),
    .pop_o         (pop),
    .issue_valid_o (issue_valid_o),
    .issue_ready_i (issue_ready_i),
    .issue_data_o  (issue_data_o),
    .issue_prio_o  (issue_prio_o),
    .done_i        (done_i),
    .active_o      (active_o),
    .active_id_o   (active_id_o)
  );
endmodule

// File: tb/desc_prio_arbiter_test.sv
`timescale 1ns/1ps
module desc_prio_arbiter_test;
  import dpq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        norm_valid = 0, prio_valid = 0;
  desc_t       norm_data = '0, prio_data = '0;
  logic        norm_ready, prio_ready;
  logic        iss_valid, iss_ready = 0, iss_prio;
  desc_t       iss_data;
  logic        cons_done = 0, stray_done = 0, done;
  logic        active, coll;
  logic [7:0]  active_id;

  assign done = cons_done | stray_done;

  desc_prio_arbiter #(.DEPTH(4), .LAT(3)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .norm_valid_i(norm_valid), .norm_data_i(norm_data), .norm_ready_o(norm_ready),
    .prio_valid_i(prio_valid), .prio_data_i(prio_data), .prio_ready_o(prio_ready),
    .issue_valid_o(iss_valid), .issue_ready_i(iss_ready), .issue_data_o(iss_data),
    .issue_prio_o(iss_prio), .done_i(done), .active_o(active),
    .active_id_o(active_id), .id_collision_o(coll)
  );

  int total = 0, bad = 0;
  desc_t nq[$], pq[$], log_d[$];
  bit    log_p[$];
  int    n_sent = 0, p_sent = 0, coll_cnt = 0, wait_cnt = 0;
  logic [2:0] n_hist = '0, p_hist = '0;
  bit    cons_accept = 1, cons_hold = 0, cons_busy = 0;

  function automatic desc_t mk(logic [7:0] id, int tag);
    return {id, 24'(tag), 128'(tag * 32'h9E3779B1)};
  endfunction

  task automatic chk(bit ok, string req, logic [159:0] act, logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // senders honour the 3-cycle ready latency
  always @(negedge clk) begin
    if (!rst_n) begin
      n_hist = '0; p_hist = '0; norm_valid = 0; prio_valid = 0;
    end else begin
      if (n_hist[2] && nq.size() != 0) begin
        norm_data = nq.pop_front(); norm_valid = 1; n_sent++;
      end else norm_valid = 0;
      if (p_hist[2] && pq.size() != 0) begin
        prio_data = pq.pop_front(); prio_valid = 1; p_sent++;
      end else prio_valid = 0;
      n_hist = {n_hist[1:0], norm_ready};
      p_hist = {p_hist[1:0], prio_ready};
    end
  end

  // downstream engine model
  always @(negedge clk) begin
    if (!rst_n) begin
      cons_busy = 0; cons_done = 0; iss_ready = 0;
    end else begin
      cons_done = 0;
      if (cons_busy) begin
        if (wait_cnt != 0) wait_cnt--;
        else if (!cons_hold) begin cons_done = 1; cons_busy = 0; end
      end
      iss_ready = cons_accept && !cons_busy && !cons_done;
      if (iss_valid && iss_ready) begin
        log_d.push_back(iss_data); log_p.push_back(iss_prio);
        cons_busy = 1; wait_cnt = 2;
      end
      if (coll) coll_cnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_log(int n);
    while (log_d.size() < n) @(negedge clk);
  endtask

  task automatic drain();
    cons_hold = 0; cons_accept = 1;
    for (int k = 0; k < 2; k++) begin
      cyc(8);
      while (nq.size() != 0 || pq.size() != 0 || active || iss_valid) @(negedge clk);
    end
    cyc(4);
  endtask

  task automatic occupy(logic [7:0] id, int tag);
    int base;
    base = log_d.size();
    cons_hold = 1; cons_accept = 1;
    nq.push_back(mk(id, tag));
    wait_log(base + 1);
    cyc(2);
  endtask

  task automatic t_reset();
    chk(!norm_ready && !prio_ready, "R2 ready low in reset", {norm_ready, prio_ready}, 0);
    @(negedge clk);
    rst_n = 1;
    #0.5;
    chk(!norm_ready && !prio_ready, "R2 ready low first cycle", {norm_ready, prio_ready}, 0);
    chk(!iss_valid && !active && !coll, "R2 outputs idle", {iss_valid, active, coll}, 0);
    @(negedge clk);
    chk(norm_ready && prio_ready, "R2 ready high after edge", {norm_ready, prio_ready}, 2'b11);
  endtask

  task automatic t_single();
    desc_t d;
    int base;
    base = log_d.size();
    d = mk(8'h11, 1);
    cons_hold = 1;
    nq.push_back(d);
    wait_log(base + 1);
    chk(log_d[base] == d, "R3 captured word issued", log_d[base], d);
    chk(log_p[base] == 0, "R11 normal source flag", log_p[base], 0);
    cyc(1);
    chk(active && active_id == 8'h11, "R11 active id", {active, active_id}, {1'b1, 8'h11});
    cons_hold = 0;
    cyc(6);
    chk(!active, "R11 active cleared after done", active, 0);
    drain();
  endtask

  task automatic t_order();
    desc_t e[4];
    int base;
    occupy(8'h20, 10);
    base = log_d.size();
    e[0] = mk(8'h40, 12); e[1] = mk(8'h41, 13);
    e[2] = mk(8'h21, 14); e[3] = mk(8'h22, 15);
    nq.push_back(e[2]); nq.push_back(e[3]);
    pq.push_back(e[0]); pq.push_back(e[1]);
    cyc(14);
    chk(active && active_id == 8'h20, "R6 no preemption", active_id, 8'h20);
    chk(log_d.size() == base, "R6 nothing issued while busy", log_d.size(), base);
    drain();
    for (int i = 0; i < 4; i++) begin
      chk(log_d[base+i] == e[i], "R5 R7 issue order", log_d[base+i], e[i]);
      chk(log_p[base+i] == (i < 2), "R11 source flag", log_p[base+i], (i < 2));
    end
  endtask

  task automatic t_fill();
    desc_t e[6];
    int base, sent0;
    occupy(8'h30, 20);
    base = log_d.size();
    sent0 = n_sent;
    for (int i = 0; i < 6; i++) begin
      e[i] = mk(8'h31 + 8'(i), 21 + i);
      nq.push_back(e[i]);
    end
    cyc(20);
    chk(n_sent - sent0 == 4, "R1 burst limited to depth", n_sent - sent0, 4);
    chk(!norm_ready, "R1 ready low when full", norm_ready, 0);
    chk(nq.size() == 2, "R1 sender held back", nq.size(), 2);
    drain();
    for (int i = 0; i < 6; i++)
      chk(log_d[base+i] == e[i], "R4 fifo order no loss", log_d[base+i], e[i]);
  endtask

  task automatic t_collision();
    int c0;
    c0 = coll_cnt;
    occupy(8'h50, 40);
    nq.push_back(mk(8'h33, 41));
    pq.push_back(mk(8'h34, 42));
    cyc(12);
    chk(coll_cnt == c0, "R10 distinct ids no pulse", coll_cnt, c0);
    drain();
    occupy(8'h51, 43);
    nq.push_back(mk(8'h33, 44));
    cyc(12);
    pq.push_back(mk(8'h33, 45));
    cyc(12);
    chk(coll_cnt == c0 + 1, "R10 id held in other queue", coll_cnt, c0 + 1);
    drain();
    occupy(8'h52, 46);
    nq.push_back(mk(8'h77, 47));
    pq.push_back(mk(8'h77, 48));
    cyc(12);
    chk(coll_cnt == c0 + 2, "R10 same id same cycle", coll_cnt, c0 + 2);
    drain();
    pq.push_back(mk(8'h33, 49));
    drain();
    chk(coll_cnt == c0 + 2, "R10 id released after issue", coll_cnt, c0 + 2);
  endtask

  task automatic t_stall();
    desc_t d;
    d = mk(8'h60, 60);
    cons_accept = 0;
    nq.push_back(d);
    while (!iss_valid) @(negedge clk);
    cyc(2);
    stray_done = 1;
    @(negedge clk);
    stray_done = 0;
    cyc(4);
    chk(iss_valid == 1, "R9 stray done ignored", iss_valid, 1);
    chk(iss_data == d, "R8 data held during stall", iss_data, d);
    drain();
    chk(log_d[log_d.size()-1] == d, "R8 stalled word delivered", log_d[log_d.size()-1], d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    t_single();
    t_order();
    t_fill();
    t_collision();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule